// File: doc/BRIEF.md
# SMBus Slave Address Match Unit

This block decides whether a two-wire serial bus slave should acknowledge an address phase, and which of its targets was addressed. The bit-level front end delivers each address byte already assembled, as eight bits with a one-cycle strobe, and marks stop conditions with a separate one-cycle pulse. The block compares each delivered byte against the enabled targets. These are a programmable slave address in 7-bit or 10-bit form and four fixed special addresses: host header, default address, alert response and general call. The block answers with a one-cycle acknowledge decision and a latched one-hot match type.

After a complete match the block can request that the bus clock be held low. That request stays up until the host side acknowledges it. The block also drives the active-low alert line. The line is modelled as an output enable that follows the alert enable.

A synchronous software reset returns the matcher to its idle state at any time. Bytes that arrive after a match, or after a failed address, are data or traffic for another device, and the block ignores them until the next stop.

Top module: `smb_addr_match`

## Requirements
- R1: In 7-bit mode (`ten_bit_en`=0), a first byte whose bits [7:1] equal `own_addr[6:0]` with `slave_en`=1 is acknowledged. `addr_ack` pulses high for exactly one cycle, in the cycle after the strobe, and `match_type[0]` is set. Bit 0 of the byte is the read/write bit and is not compared.
- R2: Each special address is acknowledged only while its enable is set, and sets its own `match_type` bit. The addresses and bits are: host header 7'h08 on bit 1 (`hh_en`), default address 7'h61 on bit 2 (`da_en`), alert response 7'h0C on bit 3 (`ara_en`), general call 7'h00 on bit 4 (`gc_en`). A disabled address gets no acknowledge.
- R3: `match_type` is one-hot or zero. When several targets match the same byte, the lowest-numbered bit wins.
- R4: In 10-bit mode, a first byte with bits [7:1] = {5'b11110, `own_addr[9:8]`} and `slave_en`=1 is acknowledged, but sets no match type. The next byte must equal `own_addr[7:0]`. If it does, that byte is acknowledged and `match_type[0]` is set. If it does not, there is no acknowledge. In 10-bit mode a 7-bit compare with `own_addr[6:0]` never matches.
- R5: After a match or a failed address, further strobes produce no acknowledge and leave `match_type` unchanged until a stop or a software reset.
- R6: A `stop` pulse clears `match_type` one cycle later and makes the next byte an address again. A `stop` in the same cycle as a strobe wins, and that byte is not acknowledged.
- R7: When `stretch_en`=1, a completed match raises `stretch_req` in the cycle after the strobe. It holds until `stretch_ack` is seen. No match, or `stretch_en`=0, leaves it low. A 10-bit header alone is not a completed match.
- R8: `sw_rst`=1 clears `match_type` and `stretch_req` on the next cycle and returns the matcher to idle. `sw_rst`=0 has no effect.
- R9: `alert_oe` equals `ara_en` delayed by one cycle (1 = alert line pulled low). It is 0 after reset.
- R10: Synchronous active-high reset gives `addr_ack`=0, `match_type`=0, `stretch_req`=0 and `alert_oe`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_in | input | 8 | Assembled address byte, read/write bit in bit 0 |
| byte_stb | input | 1 | One-cycle strobe that marks `byte_in` as valid |
| stop | input | 1 | One-cycle stop-condition pulse |
| sw_rst | input | 1 | Software reset of the match state |
| own_addr | input | 10 | Programmed slave address |
| ten_bit_en | input | 1 | 10-bit address mode |
| slave_en | input | 1 | Enable for the programmed slave address |
| hh_en | input | 1 | Enable for the host header address |
| da_en | input | 1 | Enable for the default address |
| ara_en | input | 1 | Alert enable: acknowledge alert response and pull the alert line |
| gc_en | input | 1 | Enable for the general call address |
| stretch_en | input | 1 | Request clock stretching after a match |
| stretch_ack | input | 1 | Host-side release of the stretch request |
| addr_ack | output | 1 | One-cycle acknowledge decision for the last byte |
| match_type | output | 5 | One-hot match type: slave, host header, default, alert response, general call |
| stretch_req | output | 1 | Clock-stretch request |
| alert_oe | output | 1 | Output enable of the open-drain alert line |

## Verification
All 128 first-byte addresses are swept under two enable sets. The first set has every target on, so each special address hits and the programmed address is separated from them. The second set turns the slave and two specials off, which shows that each enable gates only its own address. Each sweep repeats with the read/write bit flipped, which shows that bit is ignored.

In 10-bit mode, all 256 second bytes are swept behind a correct header, so exactly one value may match. A wrong header, data bytes after a match, and a 7-bit hit on the low address bits are each sent and must get no acknowledge. Directed sequences cover stretch hold and release, software reset in mid-transfer, a stop that collides with a strobe, and the one-cycle delay of the alert line.

// File: rtl/smb_am_pkg.sv
package smb_am_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 10;
  localparam int A7_W   = 7;
  localparam int MT_W   = 5;

  localparam int MT_SLV = 0;
  localparam int MT_HH  = 1;
  localparam int MT_DA  = 2;
  localparam int MT_ARA = 3;
  localparam int MT_GC  = 4;

  // fixed 7-bit targets, slot MT_SLV unused (programmable)
  localparam logic [MT_W*A7_W-1:0] SPEC_ADDRS =
    {7'h00, 7'h0C, 7'h61, 7'h08, 7'h00};

  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TEN  = 2'd1,
    ST_HIT  = 2'd2,
    ST_SKIP = 2'd3
  } am_state_t;
endpackage

// File: rtl/smb_am_cmp.sv
module smb_am_cmp
  import smb_am_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [ADR_W-1:0]  own_addr,
  input  logic              ten_bit_en,
  input  logic [MT_W-1:0]   tgt_en,
  output logic [MT_W-1:0]   hit7,
  output logic              hdr_hit,
  output logic              lo_hit
);
  logic [A7_W-1:0] a7;
  logic [MT_W-1:0] raw;

  assign a7 = byte_in[BYTE_W-1:1];

  assign raw[MT_SLV] = tgt_en[MT_SLV] && !ten_bit_en && (a7 == own_addr[A7_W-1:0]);

  for (genvar i = 1; i < MT_W; i++) begin : g_spec
    assign raw[i] = tgt_en[i] && (a7 == SPEC_ADDRS[i*A7_W +: A7_W]);
  end

  // lowest set bit wins
  assign hit7    = raw & (~raw + 1'b1);
  assign hdr_hit = tgt_en[MT_SLV] && ten_bit_en &&
                   (a7 == {TEN_PREFIX, own_addr[ADR_W-1:BYTE_W]});
  assign lo_hit  = (byte_in == own_addr[BYTE_W-1:0]);

  always_comb begin
    a_r3_hit_onehot: assert ($onehot0(hit7));
  end
endmodule

// File: rtl/smb_am_ctl.sv
module smb_am_ctl
  import smb_am_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            byte_stb,
  input  logic            stop,
  input  logic            sw_rst,
  input  logic            stretch_en,
  input  logic            stretch_ack,
  input  logic [MT_W-1:0] hit7,
  input  logic            hdr_hit,
  input  logic            lo_hit,
  output logic            addr_ack,
  output logic [MT_W-1:0] match_type,
  output logic            stretch_req
);
  am_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      addr_ack    <= 1'b0;
      match_type  <= '0;
      stretch_req <= 1'b0;
    end else begin
      addr_ack <= 1'b0;
      if (sw_rst) begin
        state       <= ST_IDLE;
        match_type  <= '0;
        stretch_req <= 1'b0;
      end else if (stop) begin
        state      <= ST_IDLE;
        match_type <= '0;
        if (stretch_ack) stretch_req <= 1'b0;
      end else begin
        if (stretch_ack) stretch_req <= 1'b0;
        if (byte_stb) begin
          case (state)
            ST_IDLE: begin
              if (|hit7) begin
                addr_ack   <= 1'b1;
                match_type <= hit7;
                state      <= ST_HIT;
                if (stretch_en) stretch_req <= 1'b1;
              end else if (hdr_hit) begin
                addr_ack <= 1'b1;
                state    <= ST_TEN;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_TEN: begin
              if (lo_hit) begin
                addr_ack           <= 1'b1;
                match_type         <= '0;
                match_type[MT_SLV] <= 1'b1;
                state              <= ST_HIT;
                if (stretch_en) stretch_req <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r3_type_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_type));

  a_r1_ack_after_strobe: assert property (@(posedge clk) disable iff (rst)
    addr_ack |-> $past(byte_stb));

  a_r4_second_byte: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TEN && byte_stb && lo_hit && !stop && !sw_rst)
      |=> (addr_ack && match_type[MT_SLV]));

  a_r5_hold_after_hit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIT && !stop && !sw_rst) |=> ($stable(match_type) && !addr_ack));

  a_r6_stop_clears: assert property (@(posedge clk) disable iff (rst)
    stop |=> (match_type == '0 && !addr_ack));

  a_r7_stretch_hold: assert property (@(posedge clk) disable iff (rst)
    (stretch_req && !stretch_ack && !sw_rst) |=> stretch_req);

  a_r8_swrst_clears: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (match_type == '0 && !stretch_req));
endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match
  import smb_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_stb,
  input  logic              stop,
  input  logic              sw_rst,
  input  logic [ADR_W-1:0]  own_addr,
  input  logic              ten_bit_en,
  input  logic              slave_en,
  input  logic              hh_en,
  input  logic              da_en,
  input  logic              ara_en,
  input  logic              gc_en,
  input  logic              stretch_en,
  input  logic              stretch_ack,
  output logic              addr_ack,
  output logic [MT_W-1:0]   match_type,
  output logic              stretch_req,
  output logic              alert_oe
);
  logic [MT_W-1:0] tgt_en;
  logic [MT_W-1:0] hit7;
  logic            hdr_hit;
  logic            lo_hit;

  assign tgt_en = {gc_en, ara_en, da_en, hh_en, slave_en};

  smb_am_cmp u_cmp (
    .byte_in    (byte_in),
    .own_addr   (own_addr),
    .ten_bit_en (ten_bit_en),
    .tgt_en     (tgt_en),
    .hit7       (hit7),
    .hdr_hit    (hdr_hit),
    .lo_hit     (lo_hit)
  );

  smb_am_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .byte_stb    (byte_stb),
    .stop        (stop),
    .sw_rst      (sw_rst),
    .stretch_en  (stretch_en),
    .stretch_ack (stretch_ack),
    .hit7        (hit7),
    .hdr_hit     (hdr_hit),
    .lo_hit      (lo_hit),
    .addr_ack    (addr_ack),
    .match_type  (match_type),
    .stretch_req (stretch_req)
  );

  always_ff @(posedge clk) begin
    if (rst) alert_oe <= 1'b0;
    else     alert_oe <= ara_en;
  end

  a_r9_alert_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (alert_oe == $past(ara_en)));
endmodule

// File: tb/smb_addr_match_tb.sv
module smb_addr_match_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byte_in = '0;
  logic       byte_stb = 1'b0, stop = 1'b0, sw_rst = 1'b0;
  logic [9:0] own_addr = 10'h02A;
  logic       ten_bit_en = 1'b0, slave_en = 1'b1, hh_en = 1'b1, da_en = 1'b1;
  logic       ara_en = 1'b1, gc_en = 1'b1, stretch_en = 1'b0, stretch_ack = 1'b0;
  logic       addr_ack, stretch_req, alert_oe;
  logic [4:0] match_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smb_addr_match u_dut (
    .clk(clk), .rst(rst), .byte_in(byte_in), .byte_stb(byte_stb), .stop(stop),
    .sw_rst(sw_rst), .own_addr(own_addr), .ten_bit_en(ten_bit_en),
    .slave_en(slave_en), .hh_en(hh_en), .da_en(da_en), .ara_en(ara_en),
    .gc_en(gc_en), .stretch_en(stretch_en), .stretch_ack(stretch_ack),
    .addr_ack(addr_ack), .match_type(match_type), .stretch_req(stretch_req),
    .alert_oe(alert_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected one-hot for a first byte, lowest bit wins
  function automatic logic [4:0] exp7(input logic [6:0] a);
    logic [4:0] raw;
    raw[0] = slave_en && !ten_bit_en && (a == own_addr[6:0]);
    raw[1] = hh_en && (a == 7'h08);
    raw[2] = da_en && (a == 7'h61);
    raw[3] = ara_en && (a == 7'h0C);
    raw[4] = gc_en && (a == 7'h00);
    return raw & (~raw + 5'd1);
  endfunction

  // outputs sampled at the negedge after the capturing posedge
  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_in = b; byte_stb = 1'b1;
    @(negedge clk); byte_stb = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ack", {7'd0, addr_ack}, 8'd0);
    chk("R10 type", {3'd0, match_type}, 8'd0);
    chk("R10 stretch", {7'd0, stretch_req}, 8'd0);
    chk("R10 alert", {7'd0, alert_oe}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 alert on", {7'd0, alert_oe}, 8'd1);

    // R1/R2/R3 sweep, all enables on, then a subset
    for (int cfg = 0; cfg < 2; cfg++) begin
      slave_en = (cfg == 0); da_en = (cfg == 0); gc_en = (cfg == 0);
      hh_en = 1'b1; ara_en = 1'b1;
      for (int rw = 0; rw < 2; rw++) begin
        for (int a = 0; a < 128; a++) begin
          logic [4:0] e;
          e = exp7(a[6:0]);
          do_stop();
          send({a[6:0], rw[0]});
          chk("R1 R2 ack", {7'd0, addr_ack}, {7'd0, |e});
          chk("R2 R3 type", {3'd0, match_type}, {3'd0, e});
        end
      end
    end
    slave_en = 1'b1; hh_en = 1'b1; da_en = 1'b1; ara_en = 1'b1; gc_en = 1'b1;

    // R3 priority: slave programmed to host header address
    own_addr = 10'h008;
    do_stop(); send(8'h10);
    chk("R3 priority", {3'd0, match_type}, 8'h01);
    own_addr = 10'h02A;

    // R5 data bytes after match ignored
    do_stop(); send({7'h2A, 1'b0});
    send(8'h10);
    chk("R5 ack", {7'd0, addr_ack}, 8'd0);
    chk("R5 type", {3'd0, match_type}, 8'h01);
    // R5 after a miss, even a valid address is ignored
    do_stop(); send(8'hEE); send({7'h2A, 1'b0});
    chk("R5 miss ack", {7'd0, addr_ack}, 8'd0);

    // R6 stop clears, stop beats strobe
    do_stop();
    chk("R6 cleared", {3'd0, match_type}, 8'd0);
    @(negedge clk); byte_in = 8'h54; byte_stb = 1'b1; stop = 1'b1;
    @(negedge clk); byte_stb = 1'b0; stop = 1'b0;
    chk("R6 collide", {7'd0, addr_ack}, 8'd0);
    send(8'h54);
    chk("R6 addr again", {7'd0, addr_ack}, 8'd1);

    // R4 ten-bit sweep, own 10'h2B5
    own_addr = 10'h2B5; ten_bit_en = 1'b1;
    for (int lo = 0; lo < 256; lo++) begin
      do_stop();
      send({5'b11110, 2'b10, lo[0]});
      chk("R4 header ack", {7'd0, addr_ack}, 8'd1);
      chk("R4 header type", {3'd0, match_type}, 8'd0);
      send(lo[7:0]);
      chk("R4 second ack", {7'd0, addr_ack}, {7'd0, lo[7:0] == 8'hB5});
      chk("R4 second type", {3'd0, match_type}, (lo[7:0] == 8'hB5) ? 8'h01 : 8'h00);
    end
    do_stop(); send({5'b11110, 2'b01, 1'b0});
    chk("R4 wrong header", {7'd0, addr_ack}, 8'd0);
    send(8'hB5);
    chk("R4 after wrong header", {7'd0, addr_ack}, 8'd0);
    do_stop(); send({7'h35, 1'b0});
    chk("R4 no 7-bit match", {7'd0, addr_ack}, 8'd0);
    ten_bit_en = 1'b0; own_addr = 10'h02A;

    // R7 stretch
    stretch_en = 1'b1;
    do_stop(); send(8'h02);
    chk("R7 no match", {7'd0, stretch_req}, 8'd0);
    do_stop(); send({7'h2A, 1'b1});
    chk("R7 raised", {7'd0, stretch_req}, 8'd1);
    repeat (4) @(negedge clk);
    do_stop();
    chk("R7 held", {7'd0, stretch_req}, 8'd1);
    @(negedge clk); stretch_ack = 1'b1;
    @(negedge clk); stretch_ack = 1'b0;
    chk("R7 released", {7'd0, stretch_req}, 8'd0);
    own_addr = 10'h2B5; ten_bit_en = 1'b1;
    do_stop(); send({5'b11110, 2'b10, 1'b0});
    chk("R7 header only", {7'd0, stretch_req}, 8'd0);
    ten_bit_en = 1'b0; own_addr = 10'h02A;
    stretch_en = 1'b0;
    do_stop(); send({7'h2A, 1'b0});
    chk("R7 disabled", {7'd0, stretch_req}, 8'd0);

    // R8 software reset
    stretch_en = 1'b1;
    do_stop(); send({7'h2A, 1'b0});
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    chk("R8 type", {3'd0, match_type}, 8'd0);
    chk("R8 stretch", {7'd0, stretch_req}, 8'd0);
    send(8'h10);
    chk("R8 idle again", {3'd0, match_type}, 8'h02);
    stretch_ack = 1'b1; @(negedge clk); stretch_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 zero no effect", {3'd0, match_type}, 8'h02);

    // R9 alert line follows enable with one cycle delay
    @(negedge clk); ara_en = 1'b0;
    chk("R9 not yet", {7'd0, alert_oe}, 8'd1);
    @(negedge clk);
    chk("R9 released", {7'd0, alert_oe}, 8'd0);
    ara_en = 1'b1;
    @(negedge clk);
    chk("R9 pulled", {7'd0, alert_oe}, 8'd1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule